// File: doc/BRIEF.md
# Reset Qualifier and Watchdog Router

This block produces the chip-internal system reset and the non-maskable interrupt request. The active-low external reset pin is first brought into the clock domain through a synchronizer. It is then qualified by a run-length counter. The internal reset is raised only when the synchronized pin has been low for a minimum number of consecutive clocks, so short glitches on the board are filtered out. Once qualified, the reset follows the pin and is released on the first clock after the pin is seen high again.

A watchdog timeout event, generated elsewhere and delivered as a single-cycle pulse, is routed by a one-bit route setting. With the setting at 0, the event becomes a non-maskable interrupt request. With the setting at 1, it becomes a system reset of fixed length. The route setting is itself cleared by every internal reset, so the watchdog always comes up in interrupt mode.

A separate active-low external interrupt pin is synchronized and edge-detected. Its falling edge produces a one-cycle request that is ORed with the watchdog-routed request. No enable or mask can suppress either source. The block has no data stream, so all pins are plain control signals. It has no valid/ready handshake and no back-pressure.

Top module: `rst_nmi_ctrl`

## Requirements
- R1: After the power-on reset `por_n` is released, `sys_rst` and `nmi_req` are 0 and the route setting is 0 (interrupt mode).
- R2: When `rst_pin_n` goes low and stays low, `sys_rst` rises after SYNC_STAGES+QUAL_CYCLES clock edges (14 with defaults). A low run of exactly QUAL_CYCLES clocks is enough to raise it.
- R3: A low run shorter than QUAL_CYCLES clocks never raises `sys_rst`. One high sample between two short runs restarts the count from zero.
- R4: Once qualified, `sys_rst` stays high while the pin stays low. It falls SYNC_STAGES+1 edges after the pin returns high.
- R5: A clock with `route_we`=1 loads `route_din` into the route setting. Encoding: 0 = route to interrupt, 1 = route to reset.
- R6: With route 0, a `wd_timeout` pulse gives `nmi_req`=1 for exactly one cycle, on the edge that samples it.
- R7: With route 1, a `wd_timeout` pulse raises `sys_rst` on the edge that samples it. `sys_rst` then stays high for exactly WD_RST_CYCLES cycles (12 with defaults), and no `nmi_req` is produced.
- R8: Any internal reset, whether from the pin or from the watchdog, returns the route setting to 0.
- R9: A `wd_timeout` pulse that arrives while `sys_rst` is high is ignored. It produces neither a request nor a longer reset.
- R10: A falling edge on `nmi_pin_n` gives `nmi_req`=1 for exactly one cycle, SYNC_STAGES+1 edges later. Holding the pin low gives no further pulses.
- R11: The pin-driven request cannot be blocked. It is delivered even while `sys_rst` is high, and it is ORed with the watchdog request.
- R12: A route write attempted while `sys_rst` is high has no effect. The clearing action of the reset takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset of the block's own flops, active low |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| nmi_pin_n | input | 1 | External non-maskable interrupt pin, active low, asynchronous |
| wd_timeout | input | 1 | Watchdog timeout event, one-cycle pulse |
| route_we | input | 1 | Route setting write strobe |
| route_din | input | 1 | Route value: 0 interrupt, 1 reset |
| sys_rst | output | 1 | Internal system reset, active high |
| nmi_req | output | 1 | Non-maskable interrupt request, one-cycle pulse |

## Verification
The bench builds the block with its defaults: a 2-stage synchronizer, a 12-clock qualification threshold and a 12-cycle watchdog reset. Because these are small numbers, the bench can drive low runs of exactly 11 and 12 clocks and check the outcome edge by edge. It can also count every cycle of a complete watchdog reset. Short settings also let it stack the corner cases within a few hundred cycles. These include a watchdog event and a route write landing inside an active reset, and a pin interrupt landing during reset.

// File: rtl/rnc_pkg.sv
package rnc_pkg;
  typedef enum logic {
    ROUTE_NMI   = 1'b0,
    ROUTE_RESET = 1'b1
  } wd_route_e;
endpackage

// File: rtl/rnc_sync.sv
module rnc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= RST_VAL;
        else         chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= {STAGES{RST_VAL}};
        else         chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rnc_rst_qual.sv
module rnc_rst_qual #(
  parameter int QUAL_CYCLES = 12
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_lo,
  output logic qualified
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            run_cnt <= '0;
    else if (!pin_lo)       run_cnt <= '0;
    else if (run_cnt != LIMIT) run_cnt <= run_cnt + CW'(1);
  end

  assign qualified = (run_cnt == LIMIT);
endmodule

// File: rtl/rnc_wd_route.sv
module rnc_wd_route
  import rnc_pkg::*;
#(
  parameter int WD_RST_CYCLES = 12
) (
  input  logic      clk,
  input  logic      arst_n,
  input  logic      sys_rst,
  input  logic      wd_timeout,
  input  logic      route_we,
  input  logic      route_din,
  output logic      wd_nmi,
  output logic      wd_rst_active,
  output wd_route_e route_q
);
  localparam int CW = $clog2(WD_RST_CYCLES + 1);
  localparam logic [CW-1:0] LEN = CW'(WD_RST_CYCLES);

  logic          fire;
  logic [CW-1:0] rst_left;

  assign fire = wd_timeout & ~sys_rst;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       route_q <= ROUTE_NMI;
    else if (sys_rst)  route_q <= ROUTE_NMI;
    else if (route_we) route_q <= wd_route_e'(route_din);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                             rst_left <= '0;
    else if (fire && route_q == ROUTE_RESET) rst_left <= LEN;
    else if (rst_left != '0)                 rst_left <= rst_left - CW'(1);
  end

  assign wd_nmi        = fire && (route_q == ROUTE_NMI);
  assign wd_rst_active = (rst_left != '0);
endmodule

// File: rtl/rnc_nmi_edge.sv
module rnc_nmi_edge (
  input  logic clk,
  input  logic arst_n,
  input  logic lvl,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) prev <= 1'b1;
    else         prev <= lvl;
  end

  assign fall = prev & ~lvl;
endmodule

// File: rtl/rst_nmi_ctrl.sv
module rst_nmi_ctrl
  import rnc_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int QUAL_CYCLES   = 12,
  parameter int WD_RST_CYCLES = 12
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic nmi_pin_n,
  input  logic wd_timeout,
  input  logic route_we,
  input  logic route_din,
  output logic sys_rst,
  output logic nmi_req
);
  logic      rst_lvl;
  logic      nmi_lvl;
  logic      pin_qual;
  logic      nmi_fall;
  logic      wd_nmi;
  logic      wd_rst_active;
  wd_route_e route_q;

  rnc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
    .clk(clk), .arst_n(por_n), .d(rst_pin_n), .q(rst_lvl)
  );

  rnc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
    .clk(clk), .arst_n(por_n), .d(nmi_pin_n), .q(nmi_lvl)
  );

  rnc_rst_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .arst_n(por_n), .pin_lo(~rst_lvl), .qualified(pin_qual)
  );

  rnc_nmi_edge u_edge (
    .clk(clk), .arst_n(por_n), .lvl(nmi_lvl), .fall(nmi_fall)
  );

  rnc_wd_route #(.WD_RST_CYCLES(WD_RST_CYCLES)) u_route (
    .clk(clk), .arst_n(por_n), .sys_rst(sys_rst), .wd_timeout(wd_timeout),
    .route_we(route_we), .route_din(route_din), .wd_nmi(wd_nmi),
    .wd_rst_active(wd_rst_active), .route_q(route_q)
  );

  assign sys_rst = pin_qual | wd_rst_active;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) nmi_req <= 1'b0;
    else        nmi_req <= nmi_fall | wd_nmi;
  end
endmodule

// File: rtl/rnc_checker.sv
module rnc_checker #(
  parameter int QUAL_CYCLES   = 12,
  parameter int WD_RST_CYCLES = 12
) (
  input logic clk,
  input logic por_n,
  input logic sys_rst,
  input logic nmi_req,
  input logic wd_timeout,
  input logic route_q,
  input logic rst_lvl,
  input logic nmi_fall
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam int WW = $clog2(WD_RST_CYCLES + 1);

  logic [QW-1:0] low_run;
  logic [WW-1:0] wd_left;
  logic          wd_to_rst;

  assign wd_to_rst = wd_timeout && !sys_rst && route_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                           low_run <= '0;
    else if (rst_lvl)                     low_run <= '0;
    else if (low_run != QW'(QUAL_CYCLES)) low_run <= low_run + QW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             wd_left <= '0;
    else if (wd_to_rst)     wd_left <= WW'(WD_RST_CYCLES);
    else if (wd_left != '0) wd_left <= wd_left - WW'(1);
  end

  // R2
  rise_qualified_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> (low_run == QW'(QUAL_CYCLES)) || $past(wd_to_rst));

  // R6
  wd_to_nmi_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wd_timeout && !sys_rst && !route_q) |=> nmi_req);

  // R7
  wd_rst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wd_left != '0) |-> sys_rst);

  // R8
  rst_clears_route_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !route_q);

  // R9
  wd_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wd_timeout && sys_rst && !nmi_fall) |=> !nmi_req);

  // R11
  nmi_unblocked_chk: assert property (@(posedge clk) disable iff (!por_n)
    nmi_fall |=> nmi_req);
endmodule

bind rst_nmi_ctrl rnc_checker #(
  .QUAL_CYCLES(QUAL_CYCLES), .WD_RST_CYCLES(WD_RST_CYCLES)
) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .nmi_req(nmi_req),
  .wd_timeout(wd_timeout), .route_q(route_q), .rst_lvl(rst_lvl),
  .nmi_fall(nmi_fall)
);

// File: tb/rst_nmi_ctrl_test.sv
`timescale 1ns/1ps
module rst_nmi_ctrl_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin_n = 1'b1;
  logic nmi_pin_n = 1'b1;
  logic wd_timeout = 1'b0;
  logic route_we = 1'b0;
  logic route_din = 1'b0;
  logic sys_rst;
  logic nmi_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rst_nmi_ctrl uut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .nmi_pin_n(nmi_pin_n),
    .wd_timeout(wd_timeout), .route_we(route_we), .route_din(route_din),
    .sys_rst(sys_rst), .nmi_req(nmi_req)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_route(logic v);
    route_we = 1'b1; route_din = v; tick();
    route_we = 1'b0; route_din = 1'b0;
  endtask

  task automatic pulse_wd();
    wd_timeout = 1'b1; tick(); wd_timeout = 1'b0;
  endtask

  // R1: power-on state and default routing
  task automatic t_reset_state();
    idle(3);
    check("R1", "sys_rst during por", sys_rst, 0);
    check("R1", "nmi_req during por", nmi_req, 0);
    por_n = 1'b1;
    idle(2);
    check("R1", "sys_rst after por", sys_rst, 0);
    pulse_wd();
    check("R1", "default route gives nmi", nmi_req, 1);
    check("R1", "default route no reset", sys_rst, 0);
    tick();
    check("R1", "nmi one cycle", nmi_req, 0);
  endtask

  // R2 and R4: qualification latency, hold and release
  task automatic t_pin_qualify();
    int early = 0;
    int held = 1;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 13; i++) begin
      tick();
      early += sys_rst;
    end
    check("R2", "no reset before 14 edges", early, 0);
    tick();
    check("R2", "reset at edge 14", sys_rst, 1);
    for (int i = 0; i < 10; i++) begin
      tick();
      held &= sys_rst;
    end
    check("R4", "reset held while low", held, 1);
    rst_pin_n = 1'b1;
    idle(2);
    check("R4", "still high 2 edges after release", sys_rst, 1);
    tick();
    check("R4", "released 3 edges after release", sys_rst, 0);
    idle(3);
  endtask

  // R2 and R3: exact boundary of the low run
  task automatic t_boundary();
    int hi = 0;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 12; i++) begin tick(); hi += sys_rst; end
    rst_pin_n = 1'b1;
    for (int i = 0; i < 6; i++) begin tick(); hi += sys_rst; end
    check("R2", "12-clock low run gives one reset cycle", hi, 1);
    hi = 0;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 11; i++) begin tick(); hi += sys_rst; end
    rst_pin_n = 1'b1;
    for (int i = 0; i < 6; i++) begin tick(); hi += sys_rst; end
    check("R3", "11-clock low run gives no reset", hi, 0);
  endtask

  // R3: one high sample restarts the count
  task automatic t_glitch();
    int hi = 0;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 11; i++) begin tick(); hi += sys_rst; end
    rst_pin_n = 1'b1;
    tick(); hi += sys_rst;
    rst_pin_n = 1'b0;
    for (int i = 0; i < 11; i++) begin tick(); hi += sys_rst; end
    rst_pin_n = 1'b1;
    for (int i = 0; i < 6; i++) begin tick(); hi += sys_rst; end
    check("R3", "split low runs give no reset", hi, 0);
  endtask

  // R5 and R7: watchdog routed to reset, fixed length; R8 afterwards
  task automatic t_wd_reset();
    int hi = 0;
    int nm = 0;
    set_route(1'b1);
    pulse_wd();
    check("R7", "reset on sampling edge", sys_rst, 1);
    check("R5", "route 1 gives no nmi", nmi_req, 0);
    hi = 1;
    for (int i = 0; i < 20; i++) begin
      tick();
      hi += sys_rst;
      nm += nmi_req;
    end
    check("R7", "watchdog reset length", hi, 12);
    check("R7", "no nmi during watchdog reset", nm, 0);
    pulse_wd();
    check("R8", "route cleared by watchdog reset", nmi_req, 1);
    check("R8", "no second reset", sys_rst, 0);
    tick();
  endtask

  // R8: pin reset clears the route too
  task automatic t_route_cleared_by_pin();
    set_route(1'b1);
    rst_pin_n = 1'b0;
    idle(16);
    rst_pin_n = 1'b1;
    idle(5);
    check("R8", "pin reset released", sys_rst, 0);
    pulse_wd();
    check("R8", "route cleared by pin reset", nmi_req, 1);
    check("R8", "no reset after clear", sys_rst, 0);
    tick();
  endtask

  // R6: route 0 gives a single-cycle request
  task automatic t_wd_nmi();
    set_route(1'b0);
    pulse_wd();
    check("R6", "nmi on sampling edge", nmi_req, 1);
    tick();
    check("R6", "nmi is one cycle", nmi_req, 0);
    check("R6", "no reset", sys_rst, 0);
  endtask

  // R9: watchdog event during reset is ignored
  task automatic t_wd_in_reset();
    int hi = 0;
    rst_pin_n = 1'b0;
    idle(16);
    check("R9", "pin reset active", sys_rst, 1);
    pulse_wd();
    check("R9", "no nmi from ignored event", nmi_req, 0);
    rst_pin_n = 1'b1;
    idle(3);
    check("R9", "reset released on time", sys_rst, 0);
    for (int i = 0; i < 14; i++) begin tick(); hi += sys_rst; end
    check("R9", "no extended reset", hi, 0);
  endtask

  // R12: route write during reset is dropped
  task automatic t_write_in_reset();
    rst_pin_n = 1'b0;
    idle(15);
    set_route(1'b1);
    rst_pin_n = 1'b1;
    idle(5);
    pulse_wd();
    check("R12", "write during reset dropped", nmi_req, 1);
    check("R12", "no reset from dropped write", sys_rst, 0);
    tick();
  endtask

  // R10 and R11: pin interrupt edge, hold, and delivery during reset
  task automatic t_nmi_pin();
    int cnt = 0;
    nmi_pin_n = 1'b0;
    idle(2);
    check("R10", "no request before 3 edges", nmi_req, 0);
    tick();
    check("R10", "request at edge 3", nmi_req, 1);
    for (int i = 0; i < 8; i++) begin tick(); cnt += nmi_req; end
    check("R10", "held low gives no more pulses", cnt, 0);
    nmi_pin_n = 1'b1;
    idle(4);
    rst_pin_n = 1'b0;
    idle(15);
    nmi_pin_n = 1'b0;
    idle(3);
    check("R11", "request during reset", nmi_req, 1);
    check("R11", "reset still active", sys_rst, 1);
    nmi_pin_n = 1'b1;
    rst_pin_n = 1'b1;
    idle(6);
    set_route(1'b0);
    nmi_pin_n = 1'b0;
    idle(2);
    pulse_wd();
    check("R11", "both sources give one request", nmi_req, 1);
    tick();
    check("R11", "combined request is one cycle", nmi_req, 0);
    nmi_pin_n = 1'b1;
    idle(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_pin_qualify();
    t_boundary();
    t_glitch();
    t_wd_reset();
    t_route_cleared_by_pin();
    t_wd_nmi();
    t_wd_in_reset();
    t_write_in_reset();
    t_nmi_pin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule